// File: doc/BRIEF.md
# Byte-Serial Register Command Decoder

This block turns a stream of received bytes into register accesses and memory readouts for a trace capture unit. It sits behind a byte-wide receive path and a byte-wide transmit path, such as the data side of a fast serial link. Each command is one opcode byte. The low three bits of a read or write opcode select one of eight 32-bit register slots. The block holds these registers:

- the capture frame pointer
- the trigger count
- the control word
- the memory readout count
- a fixed identification word

The status word is supplied from outside and is read-only.

A dump opcode makes the block walk the external capture memory frame by frame. It asks the memory port for each frame in turn and forwards the sixteen bytes of each frame to the transmit side. A resync opcode raises a single-cycle pulse toward the clock recovery logic and sends nothing back. Every multibyte value on the link travels least-significant byte first. The block takes no new opcode until the current reply or stream has been sent in full.

Top module: `serial_cmd_decoder`

## Requirements
- R1: A read opcode (0x10 OR index, index in bits 2:0) is answered with exactly four bytes of the selected register, least-significant byte first.
- R2: A write opcode (0x18 OR index) takes the next four received bytes, least-significant first. The register changes only on the clock edge that accepts the fourth byte.
- R3: The slots are: 0 frame pointer, 1 trigger count, 2 control word, 3 status input, 4 readout frame count, 7 identification constant. Slots 5 and 6 read as zero.
- R4: Writes to slots 3, 5, 6 and 7 are ignored. Afterwards, slot 3 still reads the status input and slot 7 still reads the identification parameter.
- R5: Opcode 0x20 requests frames on the memory port in ascending order, starting at the frame pointer, for as many frames as the count register holds. It transmits 16 bytes per frame in the order the memory returns them.
- R6: Opcode 0x20 with a zero frame count issues no memory request and sends no bytes, and the decoder is ready again at once.
- R7: Opcode 0xF0 produces a resync pulse exactly one cycle wide and no transmit bytes.
- R8: Opcode 0x00 and every opcode outside the read, write, dump and resync codes produce no reply, and the decoder then waits for a new opcode.
- R9: A transmit byte counts as sent only on a cycle where transmit-ready is high. While valid is high and ready is low, the byte stays unchanged.
- R10: The receive-ready output stays low from the acceptance of a read or dump opcode until the last byte of the reply or stream has been sent.
- R11: A read reply carries the register value as it stood on the edge that accepted the opcode. Later changes of the status input do not affect the reply.
- R12: After reset, all writable registers are zero, no byte is offered for transmit, the resync pulse is low and receive-ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Decoder accepts a received byte this cycle |
| tx_valid | output | 1 | Byte offered for transmit |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit side takes the byte this cycle |
| status_in | input | 32 | Live capture status word (slot 3) |
| cap_addr | output | 32 | Frame pointer register |
| trig_count | output | 32 | Trigger count register |
| ctrl_word | output | 32 | Control register |
| resync_pulse | output | 1 | One-cycle clock recovery resync request |
| mem_req_valid | output | 1 | Frame read request |
| mem_req_frame | output | 32 | Frame number requested |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rd_valid | input | 1 | Memory byte present |
| mem_rd_data | input | 8 | Memory byte |
| mem_rd_ready | output | 1 | Decoder takes the memory byte |

## Verification
Two events can land in the same cycle:

- **Read capture vs. status change.** The edge that accepts a status read opcode can coincide with a change on the status input.
- **Stream hand-off vs. back-pressure.** During a dump, a memory byte hand-off can meet a low transmit-ready.

The bench provokes the first case by changing the status input right after the accepting edge. It judges the case by checking that all four reply bytes match the old value. It provokes the second case by toggling transmit-ready every cycle during a multi-frame dump. It judges that case by comparing the received stream byte for byte with the arithmetic pattern of the memory model, and by checking the exact sequence of frame requests.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam logic [7:0] OP_NOP    = 8'h00;
    localparam logic [4:0] OP_RD_HI  = 5'b00010;
    localparam logic [4:0] OP_WR_HI  = 5'b00011;
    localparam logic [7:0] OP_DUMP   = 8'h20;
    localparam logic [7:0] OP_RESYNC = 8'hF0;

    localparam logic [2:0] SLOT_ADDR = 3'd0;
    localparam logic [2:0] SLOT_TRIG = 3'd1;
    localparam logic [2:0] SLOT_CTRL = 3'd2;
    localparam logic [2:0] SLOT_STAT = 3'd3;
    localparam logic [2:0] SLOT_CNT  = 3'd4;
    localparam logic [2:0] SLOT_ID   = 3'd7;

    typedef enum logic [2:0] {
        K_NOP, K_READ, K_WRITE, K_DUMP, K_RESYNC, K_OTHER
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_WDATA, ST_REPLY, ST_DUMP
    } dec_state_e;

    typedef enum logic [1:0] {
        SS_IDLE, SS_REQ, SS_DATA
    } strm_state_e;

    function automatic op_kind_e classify(input logic [7:0] b);
        if (b == OP_NOP)               return K_NOP;
        else if (b[7:3] == OP_RD_HI)   return K_READ;
        else if (b[7:3] == OP_WR_HI)   return K_WRITE;
        else if (b == OP_DUMP)         return K_DUMP;
        else if (b == OP_RESYNC)       return K_RESYNC;
        else                           return K_OTHER;
    endfunction

endpackage

// File: rtl/scd_regbank.sv
module scd_regbank
    import scd_pkg::*;
#(
    parameter int              REG_W    = 32,
    parameter logic [REG_W-1:0] ID_VALUE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic [2:0]       rd_idx,
    output logic [REG_W-1:0] rd_data,
    input  logic [REG_W-1:0] status_in,
    output logic [REG_W-1:0] addr_q,
    output logic [REG_W-1:0] trig_q,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            trig_q <= '0;
            ctrl_q <= '0;
            cnt_q  <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                SLOT_ADDR: addr_q <= wr_data;
                SLOT_TRIG: trig_q <= wr_data;
                SLOT_CTRL: ctrl_q <= wr_data;
                SLOT_CNT:  cnt_q  <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            SLOT_ADDR: rd_data = addr_q;
            SLOT_TRIG: rd_data = trig_q;
            SLOT_CTRL: rd_data = ctrl_q;
            SLOT_STAT: rd_data = status_in;
            SLOT_CNT:  rd_data = cnt_q;
            SLOT_ID:   rd_data = ID_VALUE;
            default:   rd_data = '0;
        endcase
    end

    // R4
    ctrl_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != SLOT_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/scd_streamer.sv
module scd_streamer
    import scd_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter int FRAME_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [REG_W-1:0] base_frame,
    input  logic [REG_W-1:0] frame_count,
    output logic             mem_req_valid,
    output logic [REG_W-1:0] mem_req_frame,
    input  logic             mem_req_ready,
    input  logic             mem_rd_valid,
    input  logic [7:0]       mem_rd_data,
    output logic             mem_rd_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             done
);

    localparam int BC_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
    localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(FRAME_BYTES - 1);

    strm_state_e      st;
    logic [BC_W-1:0]  bcnt;
    logic [REG_W-1:0] left;
    logic [REG_W-1:0] frame;
    logic             take;

    assign mem_req_valid = (st == SS_REQ);
    assign mem_req_frame = frame;
    assign out_valid     = (st == SS_DATA) && mem_rd_valid;
    assign out_data      = mem_rd_data;
    assign mem_rd_ready  = (st == SS_DATA) && out_ready;
    assign take          = mem_rd_valid && mem_rd_ready;
    assign done          = take && (bcnt == LAST_BYTE) && (left == REG_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SS_IDLE;
            bcnt  <= '0;
            left  <= '0;
            frame <= '0;
        end else begin
            case (st)
                SS_IDLE: if (start) begin
                    frame <= base_frame;
                    left  <= frame_count;
                    st    <= SS_REQ;
                end
                SS_REQ: if (mem_req_ready) begin
                    bcnt <= '0;
                    st   <= SS_DATA;
                end
                SS_DATA: if (take) begin
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == LAST_BYTE) begin
                        left  <= left - 1'b1;
                        frame <= frame + 1'b1;
                        st    <= (left == REG_W'(1)) ? SS_IDLE : SS_REQ;
                    end
                end
                default: st <= SS_IDLE;
            endcase
        end
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_frame)));

    // R5
    req_data_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !mem_req_valid);

endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
    import scd_pkg::*;
#(
    parameter int               REG_W       = 32,
    parameter logic [REG_W-1:0] ID_VALUE    = 32'h5C0D_E701,
    parameter int               FRAME_BYTES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    input  logic [REG_W-1:0] status_in,
    output logic [REG_W-1:0] cap_addr,
    output logic [REG_W-1:0] trig_count,
    output logic [REG_W-1:0] ctrl_word,
    output logic             resync_pulse,
    output logic             mem_req_valid,
    output logic [REG_W-1:0] mem_req_frame,
    input  logic             mem_req_ready,
    input  logic             mem_rd_valid,
    input  logic [7:0]       mem_rd_data,
    output logic             mem_rd_ready
);

    localparam int NBYTES = REG_W / 8;
    localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_B = CNT_W'(NBYTES - 1);

    dec_state_e       st;
    op_kind_e         kind;
    logic [CNT_W-1:0] bcnt;
    logic [2:0]       idx_q;
    logic [REG_W-1:0] snap, wbuf, rd_data, wr_data, cnt_q;
    logic             wr_en, s_start, s_valid, s_done, resync_q;
    logic [7:0]       s_data;

    assign kind     = classify(rx_data);
    assign rx_ready = (st == ST_IDLE) || (st == ST_WDATA);
    assign wr_en    = (st == ST_WDATA) && rx_valid && (bcnt == LAST_B);
    assign wr_data  = {rx_data, wbuf[REG_W-1:8]};
    assign s_start  = (st == ST_IDLE) && rx_valid && (kind == K_DUMP) && (cnt_q != '0);
    assign tx_valid = (st == ST_REPLY) || ((st == ST_DUMP) && s_valid);
    assign tx_data  = (st == ST_REPLY) ? snap[7:0] : s_data;
    assign resync_pulse = resync_q;

    scd_regbank #(.REG_W(REG_W), .ID_VALUE(ID_VALUE)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(idx_q), .wr_data(wr_data),
        .rd_idx(rx_data[2:0]), .rd_data(rd_data), .status_in(status_in),
        .addr_q(cap_addr), .trig_q(trig_count), .ctrl_q(ctrl_word), .cnt_q(cnt_q)
    );

    scd_streamer #(.REG_W(REG_W), .FRAME_BYTES(FRAME_BYTES)) strm_i (
        .clk(clk), .rst(rst), .start(s_start), .base_frame(cap_addr),
        .frame_count(cnt_q), .mem_req_valid(mem_req_valid),
        .mem_req_frame(mem_req_frame), .mem_req_ready(mem_req_ready),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_rd_ready(mem_rd_ready), .out_valid(s_valid), .out_data(s_data),
        .out_ready(tx_ready), .done(s_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bcnt     <= '0;
            idx_q    <= '0;
            snap     <= '0;
            wbuf     <= '0;
            resync_q <= 1'b0;
        end else begin
            resync_q <= 1'b0;
            case (st)
                ST_IDLE: if (rx_valid) begin
                    bcnt <= '0;
                    case (kind)
                        K_READ: begin
                            snap <= rd_data;
                            st   <= ST_REPLY;
                        end
                        K_WRITE: begin
                            idx_q <= rx_data[2:0];
                            st    <= ST_WDATA;
                        end
                        K_DUMP:   if (cnt_q != '0) st <= ST_DUMP;
                        K_RESYNC: resync_q <= 1'b1;
                        default: ;
                    endcase
                end
                ST_WDATA: if (rx_valid) begin
                    wbuf <= wr_data;
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == LAST_B) st <= ST_IDLE;
                end
                ST_REPLY: if (tx_ready) begin
                    snap <= snap >> 8;
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == LAST_B) st <= ST_IDLE;
                end
                ST_DUMP: if (s_done) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10
    busy_no_rx_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready);

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R7
    resync_width_chk: assert property (@(posedge clk) disable iff (rst)
        resync_pulse |=> !resync_pulse);

    // R6
    empty_dump_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !tx_valid && rx_valid && rx_data == OP_DUMP && cnt_q == '0)
        |=> (rx_ready && !mem_req_valid));

    // R7
    resync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        resync_pulse |-> !tx_valid);

endmodule

// File: tb/serial_cmd_decoder_tb_top.sv
module serial_cmd_decoder_tb_top;

    localparam logic [31:0] ID_C = 32'h5C0D_E701;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready, tx_valid, tx_ready, resync_pulse;
    logic [7:0]  tx_data;
    logic [31:0] status_in = 32'h0;
    logic [31:0] cap_addr, trig_count, ctrl_word, mem_req_frame;
    logic        mem_req_valid, mem_rd_ready;
    logic        mem_req_ready = 1'b1;
    logic        mact = 1'b0;
    logic [31:0] mfr = '0;
    logic [3:0]  mbi = '0;
    logic [7:0]  mem_rd_data;
    logic        throttle = 1'b0;

    int nchk = 0, nfail = 0, npulse = 0;
    logic [7:0]  rxq[$];
    logic [31:0] reqq[$];

    always #4 clk = ~clk;

    serial_cmd_decoder #(.ID_VALUE(ID_C)) dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .status_in(status_in), .cap_addr(cap_addr),
        .trig_count(trig_count), .ctrl_word(ctrl_word),
        .resync_pulse(resync_pulse), .mem_req_valid(mem_req_valid),
        .mem_req_frame(mem_req_frame), .mem_req_ready(mem_req_ready),
        .mem_rd_valid(mact), .mem_rd_data(mem_rd_data),
        .mem_rd_ready(mem_rd_ready)
    );

    function automatic logic [7:0] pat(input logic [31:0] f, input int i);
        logic [31:0] v;
        v = f * 16 + i;
        return v[7:0] ^ 8'hA5;
    endfunction

    assign mem_rd_data = pat(mfr, int'(mbi));

    always @(posedge clk) begin
        if (rst) tx_ready <= 1'b1;
        else tx_ready <= throttle ? ~tx_ready : 1'b1;
    end

    always @(posedge clk) begin
        if (resync_pulse) npulse++;
        if (rst) begin
            mact <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            reqq.push_back(mem_req_frame);
            mfr  <= mem_req_frame;
            mbi  <= '0;
            mact <= 1'b1;
        end else if (mact && mem_rd_ready) begin
            mbi <= mbi + 1'b1;
            if (mbi == 4'hF) mact <= 1'b0;
        end
    end

    always @(negedge clk) if (!rst && tx_valid && tx_ready) rxq.push_back(tx_data);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_bytes(input int n);
        int t = 0;
        while (rxq.size() < n && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [31:0] v);
        send_byte(8'h18 | {5'd0, idx});
        for (int k = 0; k < 4; k++) send_byte(v[8*k +: 8]);
    endtask

    task automatic rd_reg(input logic [2:0] idx, output logic [31:0] v, output int n);
        rxq.delete();
        send_byte(8'h10 | {5'd0, idx});
        wait_bytes(4);
        n = rxq.size();
        v = '0;
        for (int k = 0; k < 4 && k < n; k++) v[8*k +: 8] = rxq[k];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v, wv[8], expv;
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(rx_ready === 1'b1, "R12 rx_ready", {31'd0, rx_ready}, 1);
        chk(tx_valid === 1'b0, "R12 tx_valid", {31'd0, tx_valid}, 0);
        chk(resync_pulse === 1'b0, "R12 resync", {31'd0, resync_pulse}, 0);
        chk(ctrl_word == 0 && cap_addr == 0 && trig_count == 0, "R12 regs", ctrl_word, 0);
        rd_reg(3'd4, v, n);
        chk(n == 4 && v == 0, "R12 count reg", v, 0);

        // R2 update lands on the fourth byte
        send_byte(8'h1A);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        chk(ctrl_word == 0, "R2 before fourth byte", ctrl_word, 0);
        send_byte(8'h44);
        chk(ctrl_word == 32'h4433_2211, "R2 after fourth byte", ctrl_word, 32'h4433_2211);

        // R1 R3 R4 sweep of every slot
        status_in = 32'hC0FF_EE42;
        for (int i = 0; i < 8; i++) begin
            wv[i] = 32'hA000_0000 + i * 32'h0101_0103;
            wr_reg(i[2:0], wv[i]);
        end
        chk(cap_addr == wv[0] && trig_count == wv[1], "R3 outputs", cap_addr, wv[0]);
        for (int i = 0; i < 8; i++) begin
            case (i)
                3: expv = status_in;
                5, 6: expv = 0;
                7: expv = ID_C;
                default: expv = wv[i];
            endcase
            rd_reg(i[2:0], v, n);
            chk(n == 4, "R1 reply length", n, 4);
            chk(v == expv, (i == 3 || i >= 5) ? "R4 ignored slot" : "R3 slot value", v, expv);
        end

        // R1 with throttled transmit
        throttle = 1'b1;
        rd_reg(3'd1, v, n);
        chk(n == 4 && v == wv[1], "R1 R9 throttled read", v, wv[1]);

        // R11 status changes right after acceptance
        status_in = 32'h1234_5678;
        rxq.delete();
        send_byte(8'h13);
        status_in = 32'h8765_4321;
        wait_bytes(4);
        v = {rxq[3], rxq[2], rxq[1], rxq[0]};
        chk(rxq.size() == 4 && v == 32'h1234_5678, "R11 snapshot", v, 32'h1234_5678);

        // R5 R9 R10 multi-frame dump under back-pressure
        wr_reg(3'd0, 32'd5);
        wr_reg(3'd4, 32'd3);
        rxq.delete(); reqq.delete();
        send_byte(8'h20);
        repeat (10) @(negedge clk);
        chk(rx_ready === 1'b0, "R10 busy during dump", {31'd0, rx_ready}, 0);
        wait_bytes(48);
        chk(rxq.size() == 48, "R5 stream length", rxq.size(), 48);
        n = 0;
        for (int f = 0; f < 3; f++)
            for (int b = 0; b < 16; b++)
                if (rxq.size() == 48 && rxq[f*16+b] != pat(5 + f, b)) n++;
        chk(n == 0, "R5 R9 stream bytes", n, 0);
        chk(reqq.size() == 3 && reqq[0] == 5 && reqq[2] == 7, "R5 frame requests", reqq.size(), 3);
        chk(rx_ready === 1'b1, "R10 ready after dump", {31'd0, rx_ready}, 1);
        throttle = 1'b0;

        // R6 empty dump
        wr_reg(3'd4, 32'd0);
        rxq.delete(); reqq.delete();
        send_byte(8'h20);
        repeat (40) @(negedge clk);
        chk(rxq.size() == 0 && reqq.size() == 0, "R6 no traffic", rxq.size(), 0);
        chk(rx_ready === 1'b1, "R6 ready", {31'd0, rx_ready}, 1);

        // R7 resync
        npulse = 0;
        rxq.delete();
        send_byte(8'hF0);
        repeat (10) @(negedge clk);
        chk(npulse == 1, "R7 pulse count", npulse, 1);
        chk(rxq.size() == 0, "R7 no reply", rxq.size(), 0);

        // R8 every other opcode is silent
        n = 0;
        for (int op = 0; op < 256; op++) begin
            if (op[7:3] == 5'b00010 || op[7:3] == 5'b00011 || op == 8'h20 || op == 8'hF0)
                continue;
            rxq.delete();
            send_byte(op[7:0]);
            @(negedge clk);
            if (rxq.size() != 0 || rx_ready !== 1'b1 || tx_valid !== 1'b0) n++;
        end
        chk(n == 0, "R8 silent opcodes", n, 0);
        chk(npulse == 1, "R8 no resync", npulse, 1);
        rd_reg(3'd7, v, n);
        chk(n == 4 && v == ID_C, "R8 decoder resumes", v, ID_C);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule